// File: doc/BRIEF.md
# Batch-Reload Three-Output PWM Timer

This block is a 16-bit up-counting timer that generates three pulse-width-modulated outputs sharing one cycle length. Software programs four compare values through a single-cycle write port: slot 0 holds the cycle length and slots 1, 2 and 3 hold the on-time of outputs 1, 2 and 3. The compare logic never reads these slots directly. It reads a second set of shadow copies, and those copies are refreshed all together, so a new cycle length and new on-times always take effect in the same counter cycle.

A refresh of the shadow copies is committed by writing slot 1. Software updates any of slots 0, 2 and 3 first and writes slot 1 last, writing back its existing value if output 1 does not change. The next counter wrap then copies all four slots at once. A change to output 1 alone needs only the slot 1 write. A control word holds a run bit and a 3-bit clock divider select. The divider select is taken only at the moment counting starts. Starting also loads the shadow copies directly, and a one-cycle pulse marks every counter wrap.

Top module: `pwm_batch_timer`

## Requirements
- R1: After reset the three PWM outputs and the wrap pulse are low and the timer is stopped.
- R2: A write to address 0 sets the cycle length, addresses 1..3 set the on-times of outputs 1..3, and address 4 is the control word, with bit 0 the run bit and bits 3:1 the divider select.
- R3: While running, the counter goes from 0 up to the shadow cycle length and then clears to 0. So one counter cycle lasts (length+1) count ticks, and `wrapPulse` is high for exactly one clock right after each clear.
- R4: Output a is high while the counter is below shadow on-time a and low otherwise. An on-time of 0 gives a constant low output, and an on-time above the cycle length gives a constant high output.
- R5: A divider select of s makes one count tick every 2^s clocks, so a counter cycle lasts (length+1)*2^s clocks.
- R6: Setting the run bit while stopped copies all four slots into the shadow copies and starts the count from 0 in that same edge. The first wrap pulse appears (length+1)*2^s clocks later.
- R7: Writes to slots 0, 2 or 3 with no later slot 1 write never change the running waveform.
- R8: A slot 1 write while running arms a refresh. The next counter clear copies all four slots together and disarms.
- R9: A slot 1 write in the same clock as a refreshing clear leaves the refresh armed. That clear uses the older slot 1 value, and the following clear applies the new one.
- R10: Clearing the run bit holds the counter at 0, forces all outputs low, stops wrap pulses and discards any armed refresh.
- R11: A control write with the run bit set while already running leaves the divider unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address: 0 length, 1..3 on-times, 4 control |
| wrData | input | 16 | Write data |
| pwmOut | output | 3 | PWM outputs, bit a-1 is output a |
| wrapPulse | output | 1 | One-clock pulse after each counter clear |

## Verification
A register write is taken at the clock edge that ends its write cycle. A start therefore shows its counter value of 0 in the very next clock, and a wrap clear raises `wrapPulse` in the clock after the clear edge. Outputs follow the counter with no further register, so in the pulse clock they already reflect count 0 and any newly loaded shadow values. The bench drives on falling edges and also samples on falling edges. It measures whole counter cycles from one wrap pulse to the next, counting cycle length and high clocks per output, and compares them with (length+1)*2^s and min(on-time, length+1)*2^s. To hit a clear edge exactly, it schedules a write for the clock (length) clocks after a pulse.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic run;      // timer is counting
    logic start;    // run bit being set this cycle
    logic halt;     // run bit being cleared this cycle
    logic tick;     // divided count-enable
    logic loadBuf;  // copy compare slots into shadow copies
  } pwm_strobe_t;

  localparam int unsigned ADDR_W   = 3;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 3'd4;
  localparam logic [ADDR_W-1:0] ARM_ADDR  = 3'd1;

endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_timer_pkg::*;
#(
  parameter int unsigned PS_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PS_W:0]     ctrlData,
  input  logic              wrapNow,
  output pwm_strobe_t       strobe
);

  localparam int unsigned PSC_W = (1 << PS_W) - 1;

  logic             runQ;
  logic             armQ;
  logic [PS_W-1:0]  psSelQ;
  logic [PSC_W-1:0] psCnt;
  logic [PSC_W-1:0] psMask;
  logic             ctrlWr;
  logic             startReq;
  logic             stopReq;
  logic             armWr;
  logic             tick;

  assign ctrlWr   = wrEn && (wrAddr == CTRL_ADDR);
  assign startReq = ctrlWr && ctrlData[0] && !runQ;
  assign stopReq  = ctrlWr && !ctrlData[0] && runQ;
  assign armWr    = wrEn && (wrAddr == ARM_ADDR) && runQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      psSelQ <= '0;
    end else if (startReq) begin
      runQ   <= 1'b1;
      psSelQ <= ctrlData[PS_W:1];
    end else if (stopReq) begin
      runQ   <= 1'b0;
    end
  end

  // Free-running divider, restarted at each start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt <= '0;
    end else if (startReq || !runQ) begin
      psCnt <= '0;
    end else begin
      psCnt <= psCnt + PSC_W'(1);
    end
  end

  assign psMask = (PSC_W'(1) << psSelQ) - PSC_W'(1);
  assign tick   = runQ && ((psCnt & psMask) == psMask);

  // Refresh arm: set by slot 1 write, cleared by the refreshing clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armQ <= 1'b0;
    end else if (!runQ || stopReq) begin
      armQ <= 1'b0;
    end else if (armWr) begin
      armQ <= 1'b1;
    end else if (wrapNow && armQ) begin
      armQ <= 1'b0;
    end
  end

  assign strobe.run     = runQ;
  assign strobe.start   = startReq;
  assign strobe.halt    = stopReq;
  assign strobe.tick    = tick;
  assign strobe.loadBuf = startReq || (wrapNow && armQ);

  // R10
  arm_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runQ |-> !armQ);

  // R11
  div_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && $past(runQ)) |-> $stable(psSelQ));

endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_timer_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned NUM_DUTY = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [CNT_W-1:0]    wrData,
  input  pwm_strobe_t         strobe,
  output logic                wrapNow,
  output logic [NUM_DUTY-1:0] pwmOut,
  output logic                wrapPulse
);

  localparam int unsigned NUM_CMP = NUM_DUTY + 1;

  logic [CNT_W-1:0] cmpReg [NUM_CMP];
  logic [CNT_W-1:0] bufReg [NUM_CMP];
  logic [CNT_W-1:0] cnt;
  logic             pulseQ;

  // Software-visible compare slots
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CMP; i++) cmpReg[i] <= '0;
    end else if (wrEn) begin
      for (int i = 0; i < NUM_CMP; i++) begin
        if (wrAddr == ADDR_W'(i)) cmpReg[i] <= wrData;
      end
    end
  end

  // Shadow copies used by the compare logic
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CMP; i++) bufReg[i] <= '0;
    end else if (strobe.loadBuf) begin
      for (int i = 0; i < NUM_CMP; i++) bufReg[i] <= cmpReg[i];
    end
  end

  assign wrapNow = strobe.tick && (cnt == bufReg[0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.start || strobe.halt || !strobe.run) begin
      cnt <= '0;
    end else if (wrapNow) begin
      cnt <= '0;
    end else if (strobe.tick) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseQ <= 1'b0;
    else       pulseQ <= wrapNow && !strobe.halt;
  end

  assign wrapPulse = pulseQ;

  for (genvar g = 0; g < NUM_DUTY; g++) begin : g_out
    assign pwmOut[g] = strobe.run && (cnt < bufReg[g+1]);

    // R8
    buf_at_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(bufReg[g+1]) |-> (cnt == '0));
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run |-> (cnt <= bufReg[0]));

  // R3
  pulse_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |-> (cnt == '0));

  // R10
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |-> (cnt == '0));

  // R8
  len_at_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(bufReg[0]) |-> (cnt == '0));

endmodule

// File: rtl/pwm_batch_timer.sv
module pwm_batch_timer
  import pwm_timer_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned NUM_DUTY = 3,
  parameter int unsigned PS_W     = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [CNT_W-1:0]    wrData,
  output logic [NUM_DUTY-1:0] pwmOut,
  output logic                wrapPulse
);

  pwm_strobe_t strobe;
  logic        wrapNow;

  pwm_ctrl #(.PS_W(PS_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .ctrlData (wrData[PS_W:0]),
    .wrapNow  (wrapNow),
    .strobe   (strobe)
  );

  pwm_datapath #(.CNT_W(CNT_W), .NUM_DUTY(NUM_DUTY)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .strobe    (strobe),
    .wrapNow   (wrapNow),
    .pwmOut    (pwmOut),
    .wrapPulse (wrapPulse)
  );

endmodule

// File: tb/pwm_batch_timer_bench.sv
module pwm_batch_timer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [2:0]  pwmOut;
  logic        wrapPulse;

  int checkCnt = 0;
  int passCnt  = 0;
  bit doneFlag = 1'b0;

  always #4 clk = ~clk;

  pwm_batch_timer u_pwm_batch_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pwmOut(pwmOut), .wrapPulse(wrapPulse)
  );

  function automatic int minInt(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checkCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
  endtask

  task automatic wr(int addr, int data);
    wrEn = 1'b1; wrAddr = 3'(addr); wrData = 16'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic startRun(int sel);
    wr(4, 1 | (sel << 1));
  endtask

  task automatic stopRun();
    wr(4, 0);
  endtask

  // Measure one counter cycle, pulse to pulse
  task automatic measure(int len, int l, int d1, int d2, int d3, int div, string req);
    int guard = 0;
    int n = 0;
    int h1 = 0, h2 = 0, h3 = 0;
    int eLen = (len + 1) * div;
    while (!wrapPulse && guard < 5000) begin @(negedge clk); guard++; end
    do begin
      h1 += int'(pwmOut[0]); h2 += int'(pwmOut[1]); h3 += int'(pwmOut[2]);
      @(negedge clk); n++;
    end while (!wrapPulse && n < 5000);
    check(n == eLen, req, "cycle length", n, eLen);
    check(h1 == minInt(d1, l + 1) * div, req, "out1 high", h1, minInt(d1, l + 1) * div);
    check(h2 == minInt(d2, l + 1) * div, req, "out2 high", h2, minInt(d2, l + 1) * div);
    check(h3 == minInt(d3, l + 1) * div, req, "out3 high", h3, minInt(d3, l + 1) * div);
  endtask

  task automatic loadAll(int l, int d1, int d2, int d3);
    wr(0, l); wr(1, d1); wr(2, d2); wr(3, d3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pwmOut == 3'b000, "R1", "outputs", int'(pwmOut), 0);
    check(wrapPulse == 1'b0, "R1", "pulse", int'(wrapPulse), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(pwmOut == 3'b000 && !wrapPulse, "R1", "idle after reset", int'(pwmOut), 0);

    // R2 R6: program slots, start with divide-by-2
    loadAll(2, 1, 2, 3);
    startRun(1);
    begin
      int n = 0;
      while (!wrapPulse && n < 100) begin @(negedge clk); n++; end
      check(n == 6, "R6", "clocks to first pulse", n, 6);
    end
    measure(2, 2, 1, 2, 3, 2, "R2");

    // R10: stop
    stopRun();
    begin
      int bad = 0;
      for (int i = 0; i < 20; i++) begin
        if (pwmOut != 3'b000 || wrapPulse) bad++;
        @(negedge clk);
      end
      check(bad == 0, "R10", "activity while stopped", bad, 0);
    end

    // R5: divider sweep
    loadAll(3, 1, 2, 0);
    for (int s = 0; s < 8; s++) begin
      startRun(s);
      measure(3, 3, 1, 2, 0, 1 << s, "R5");
      stopRun();
    end

    // R4: on-time sweep
    for (int d = 0; d < 8; d++) begin
      loadAll(5, d, (d + 3) % 8, 7 - d);
      startRun(0);
      measure(5, 5, d, (d + 3) % 8, 7 - d, 1, "R4");
      stopRun();
    end

    // R3: cycle length sweep
    for (int l = 0; l < 7; l++) begin
      loadAll(l, 1, l, l + 1);
      startRun(0);
      measure(l, l, 1, l, l + 1, 1, "R3");
      stopRun();
    end

    // R7: slots 0,2,3 alone do not reach the waveform
    loadAll(3, 1, 2, 3);
    startRun(0);
    measure(3, 3, 1, 2, 3, 1, "R7");
    wr(0, 5); wr(2, 4); wr(3, 0);
    measure(3, 3, 1, 2, 3, 1, "R7");
    measure(3, 3, 1, 2, 3, 1, "R7");

    // R8: slot 1 rewrite commits all
    wr(1, 1);
    measure(5, 5, 1, 4, 0, 1, "R8");
    wr(1, 3);
    measure(5, 5, 3, 4, 0, 1, "R8");

    // R9: slot 1 write on the refreshing clear edge (now at a pulse, length 5)
    wr(0, 4);
    wr(1, 2);
    repeat (3) @(negedge clk);
    wr(1, 5);
    measure(4, 4, 2, 4, 0, 1, "R9");
    measure(4, 4, 5, 4, 0, 1, "R9");

    // R11: divider change while running ignored
    wr(4, 1 | (3 << 1));
    measure(4, 4, 5, 4, 0, 1, "R11");
    measure(4, 4, 5, 4, 0, 1, "R11");

    // R10: stop discards an armed refresh
    stopRun();
    loadAll(3, 1, 2, 3);
    startRun(0);
    wr(1, 1);
    stopRun();
    startRun(0);
    wr(0, 6);
    measure(3, 3, 1, 2, 3, 1, "R10");
    measure(3, 3, 1, 2, 3, 1, "R10");

    doneFlag = 1'b1;
    $display("%0d/%0d checks passed", passCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!doneFlag) begin
      checkCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", passCnt, checkCnt);
      $finish;
    end
  end

endmodule